// File: doc/BRIEF.md
# Dual-Mode Byte Serial Port

This block is a byte-oriented serial peripheral port. It runs either as the clock-generating master or as a slave clocked from outside. Software reaches it through two register addresses. Address 0 is the control register. Address 1 is a shared data port: writing it loads the transmit shift register, and reading it returns the receive buffer together with two status flags. The receive buffer sits behind the shift register, so a finished byte stays readable while the next one is already shifting.

As master, a write to the data port starts a transfer, provided the port is enabled and idle. The serial clock is derived in one of two ways: by dividing the system clock by 2, 4, 8 or 16, or by advancing one half period on every pulse of an external timer tick input. Selecting the slave device is left to general-purpose I/O. As slave, the serial clock, select and data inputs are synchronised into the system clock domain. The select polarity is programmable, and the serial data output can be held off the line. Both modes raise a received-byte flag at the end of each byte. That flag drives an interrupt request when the interrupt enable input is high. A byte that completes while the flag is still set records an overrun.

Top module: `spi_duplex_port`

## Requirements
- R1: After reset, the control register and the data port both read 0. The irq, sclk_oe and sdo_oe outputs are 0.
- R2: In master mode with clock source bit 6 at 0, control bits 2:1 hold a code d. The serial clock period is 2^(d+1) system clocks. The received-byte flag rises 16*2^d+1 cycles after the data write.
- R3: Master transfers are MSB first. With polarity bit 3 at 0, sclk_o idles low, data is sampled on the rising edge and shifted on the falling edge. With bit 3 at 1, all of these are inverted. sclk_o returns to its idle level once the byte is done.
- R4: With bit 6 at 1, each one-cycle pulse on tick_in advances the master serial clock by one half period. Without pulses, no transfer progresses.
- R5: A data write while a master transfer is in progress has no effect on the byte being sent.
- R6: With the enable bit 5 at 0, no transfer runs and sclk_oe and sdo_oe stay 0.
- R7: A data read returns the overrun flag in bit 15, the received-byte flag in bit 14 and the byte in bits 7:0. The read clears the received-byte flag.
- R8: irq is high exactly when the received-byte flag is set and irq_en is high.
- R9: A byte completing while the received-byte flag is set sets the overrun flag and replaces the buffer. In slave mode, control bit 1 reads the overrun flag. A control write with bits 7 and 1 both at 0 clears it.
- R10: In slave mode (bit 7 at 0), bytes move MSB first on sclk_i while ss_i is active. ss_i is active low when bit 0 is 0 and active high when bit 0 is 1. The edge roles follow bit 3 as in R3.
- R11: When ss_i goes inactive in slave mode, the bit count restarts and the shift register is cleared. A partial byte is discarded and does not set the received-byte flag.
- R12: In slave mode, sdo_oe follows control bit 2 while the port is enabled.
- R13: The control register reads back: mode in bit 7, clock source in bit 6, enable in bit 5, received-byte flag in bit 4, polarity in bit 3, bit 2 as written, bit 1 as written in master mode, and select polarity in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq_en | input | 1 | Interrupt enable for the received-byte flag |
| irq | output | 1 | Interrupt request |
| tick_in | input | 1 | External timer tick for the master clock |
| sclk_o | output | 1 | Master serial clock |
| sclk_oe | output | 1 | Master serial clock output enable |
| sclk_i | input | 1 | Slave serial clock |
| ss_i | input | 1 | Slave select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data out enable (0 = high impedance) |

## Verification
The properties assume single-cycle register strobes and single-cycle tick pulses. They also assume the mode, polarity and clock-source fields are left unchanged while a byte is moving. For slave mode they assume sclk_i, ss_i and sdi_i change slowly enough that every level lasts several system clocks after synchronisation. The bench keeps to all of this. Each serial half period it drives lasts eight system clocks. It changes configuration only between transfers. It waits for the synchroniser to settle after releasing select before reloading the transmit byte. Master transfers are swept over every divider code and both clock polarities, and slave transfers over both clock and select polarities, with a bench-side peer that supplies and captures bits independently.

// File: rtl/spi_dm_pkg.sv
`timescale 1ns/1ps
package spi_dm_pkg;
   // control register bit positions
   localparam int CB_SSPOL = 0;
   localparam int CB_DIVLO = 1;   // slave: overrun flag
   localparam int CB_DIVHI = 2;   // slave: data-out enable
   localparam int CB_CPOL  = 3;
   localparam int CB_AVAIL = 4;
   localparam int CB_EN    = 5;
   localparam int CB_SRC   = 6;
   localparam int CB_MODE  = 7;
   // data port status positions
   localparam int ST_AVAIL = 14;
   localparam int ST_OVR   = 15;
   localparam int RD_W     = 16;

   typedef struct packed {
      logic       master;
      logic       ext_src;
      logic       enable;
      logic       cpol;
      logic [1:0] div;
      logic       ss_pol;
   } spi_cfg_t;
endpackage

// File: rtl/spi_dm_regs.sv
`timescale 1ns/1ps
module spi_dm_regs
   import spi_dm_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [RD_W-1:0]   rdata,
   input  logic              irq_en,
   output logic              irq,
   input  logic              done_i,
   input  logic [DATA_W-1:0] rx_i,
   output spi_cfg_t          cfg_o,
   output logic              data_wr,
   output logic              data_rd,
   output logic              avail_o,
   output logic              ovr_o
);
   spi_cfg_t          cfg_q;
   logic              avail_q;
   logic              ovr_q;
   logic [DATA_W-1:0] rxbuf_q;
   logic              ctrl_wr;
   logic [7:0]        ctrl_view;

   assign ctrl_wr = wr && !addr;
   assign data_wr = wr && addr;
   assign data_rd = rd && addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         avail_q <= 1'b0;
         ovr_q   <= 1'b0;
         rxbuf_q <= '0;
      end else begin
         if (ctrl_wr) begin
            cfg_q.master  <= wdata[CB_MODE];
            cfg_q.ext_src <= wdata[CB_SRC];
            cfg_q.enable  <= wdata[CB_EN];
            cfg_q.cpol    <= wdata[CB_CPOL];
            cfg_q.div     <= {wdata[CB_DIVHI], wdata[CB_DIVLO]};
            cfg_q.ss_pol  <= wdata[CB_SSPOL];
            if (!wdata[CB_MODE] && !wdata[CB_DIVLO])
               ovr_q <= 1'b0;
         end
         if (done_i) begin
            rxbuf_q <= rx_i;
            avail_q <= 1'b1;
            if (avail_q && !data_rd)
               ovr_q <= 1'b1;
         end else if (data_rd) begin
            avail_q <= 1'b0;
         end
      end
   end

   always_comb begin
      ctrl_view           = '0;
      ctrl_view[CB_MODE]  = cfg_q.master;
      ctrl_view[CB_SRC]   = cfg_q.ext_src;
      ctrl_view[CB_EN]    = cfg_q.enable;
      ctrl_view[CB_AVAIL] = avail_q;
      ctrl_view[CB_CPOL]  = cfg_q.cpol;
      ctrl_view[CB_DIVHI] = cfg_q.div[1];
      ctrl_view[CB_DIVLO] = cfg_q.master ? cfg_q.div[0] : ovr_q;
      ctrl_view[CB_SSPOL] = cfg_q.ss_pol;
   end

   always_comb begin
      rdata = '0;
      if (addr) begin
         rdata[DATA_W-1:0] = rxbuf_q;
         rdata[ST_AVAIL]   = avail_q;
         rdata[ST_OVR]     = ovr_q;
      end else begin
         rdata[7:0] = ctrl_view;
      end
   end

   assign irq     = avail_q && irq_en;
   assign cfg_o   = cfg_q;
   assign avail_o = avail_q;
   assign ovr_o   = ovr_q;
endmodule

// File: rtl/spi_dm_master.sv
`timescale 1ns/1ps
module spi_dm_master #(
   parameter int DATA_W      = 8,
   parameter int DIV_LOG_MAX = 3,
   parameter bit HAS_EXT_SRC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ext_src,
   input  logic [1:0]        div,
   input  logic              cpol,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              sdi,
   output logic              sclk,
   output logic              sdo,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              busy
);
   localparam int CNT_W = DIV_LOG_MAX;
   localparam int BC_W  = $clog2(DATA_W);

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  lim;
   logic [BC_W-1:0]   bit_q;
   logic [DATA_W-1:0] sh_q;
   logic              busy_q;
   logic              sclk_q;
   logic              phase_q;   // 0: next step is the sampling edge
   logic              sbit_q;
   logic              step;
   logic              div_hit;

   always_comb lim = CNT_W'((1 << div) - 1);
   assign div_hit = (cnt_q == lim);

   generate
      if (HAS_EXT_SRC) begin : g_ext
         assign step = ext_src ? tick : div_hit;
      end else begin : g_div
         logic unused_src;
         assign unused_src = ext_src ^ tick;
         assign step = div_hit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         sclk_q  <= 1'b0;
         phase_q <= 1'b0;
         sbit_q  <= 1'b0;
         done    <= 1'b0;
         rx_byte <= '0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
            bit_q   <= '0;
            sclk_q  <= cpol;
         end else if (!busy_q) begin
            sclk_q <= cpol;
            if (load) begin
               busy_q  <= 1'b1;
               sh_q    <= load_data;
               cnt_q   <= '0;
               phase_q <= 1'b0;
               bit_q   <= '0;
            end
         end else begin
            cnt_q <= div_hit ? '0 : cnt_q + 1'b1;
            if (step) begin
               sclk_q  <= ~sclk_q;
               phase_q <= ~phase_q;
               if (!phase_q) begin
                  sbit_q <= sdi;
               end else begin
                  sh_q <= {sh_q[DATA_W-2:0], sbit_q};
                  if (bit_q == BC_W'(DATA_W-1)) begin
                     busy_q  <= 1'b0;
                     done    <= 1'b1;
                     rx_byte <= {sh_q[DATA_W-2:0], sbit_q};
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
            end
         end
      end
   end

   assign sclk = busy_q ? sclk_q : cpol;
   assign sdo  = sh_q[DATA_W-1];
   assign busy = busy_q;
endmodule

// File: rtl/spi_dm_slave.sv
`timescale 1ns/1ps
module spi_dm_slave #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              cpol,
   input  logic              ss_pol,
   input  logic              sclk_in,
   input  logic              ss_in,
   input  logic              sdi_in,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              sdo,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              ss_act,
   output logic [$clog2(DATA_W)-1:0] bit_cnt
);
   localparam int BC_W = $clog2(DATA_W);
   localparam int NSIG = 3;   // {sclk, ss, sdi}

   logic [NSIG-1:0]   sync_q [SYNC_STAGES];
   logic              s_sclk, s_ss, s_sdi;
   logic              sclk_prev_q;
   logic              act_prev_q;
   logic              lead, trail;
   logic [BC_W-1:0]   bit_q;
   logic [DATA_W-1:0] sh_q;
   logic              sbit_q;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sync_q[g] <= '0;
            else if (g == 0)
               sync_q[g] <= {sclk_in, ss_in, sdi_in};
            else
               sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign {s_sclk, s_ss, s_sdi} = sync_q[SYNC_STAGES-1];
   assign ss_act = run && (s_ss == ss_pol);
   assign lead   = cpol ? (sclk_prev_q && !s_sclk) : (!sclk_prev_q && s_sclk);
   assign trail  = cpol ? (!sclk_prev_q && s_sclk) : (sclk_prev_q && !s_sclk);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev_q <= 1'b0;
         act_prev_q  <= 1'b0;
         bit_q       <= '0;
         sh_q        <= '0;
         sbit_q      <= 1'b0;
         done        <= 1'b0;
         rx_byte     <= '0;
      end else begin
         done        <= 1'b0;
         sclk_prev_q <= s_sclk;
         act_prev_q  <= ss_act;
         if (!ss_act) begin
            bit_q <= '0;
            if (act_prev_q)
               sh_q <= '0;
            else if (load)
               sh_q <= load_data;
         end else begin
            if (lead)
               sbit_q <= s_sdi;
            if (trail) begin
               sh_q <= {sh_q[DATA_W-2:0], sbit_q};
               if (bit_q == BC_W'(DATA_W-1)) begin
                  bit_q   <= '0;
                  done    <= 1'b1;
                  rx_byte <= {sh_q[DATA_W-2:0], sbit_q};
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   assign sdo     = sh_q[DATA_W-1];
   assign bit_cnt = bit_q;
endmodule

// File: rtl/spi_duplex_port.sv
`timescale 1ns/1ps
module spi_duplex_port
   import spi_dm_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_LOG_MAX = 3,
   parameter bit HAS_EXT_SRC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              irq_en,
   output logic              irq,
   input  logic              tick_in,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              sclk_i,
   input  logic              ss_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              sdo_oe
);
   localparam int BC_W = $clog2(DATA_W);

   generate
      if (DATA_W < 8 || DATA_W > 14) begin : g_bad_width
         $error("DATA_W must lie in 8..14");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DIV_LOG_MAX < 3) begin : g_bad_div
         $error("DIV_LOG_MAX must be at least 3");
      end
   endgenerate

   spi_cfg_t          cfg;
   logic              data_wr, data_rd;
   logic              rx_avail, rx_ovr;
   logic              m_run, s_run;
   logic              m_done, s_done, done;
   logic [DATA_W-1:0] m_rx, s_rx, rx_mux;
   logic              m_sdo, s_sdo;
   logic              m_busy;
   logic              s_ss_act;
   logic [BC_W-1:0]   s_bitcnt;

   assign m_run  = cfg.enable && cfg.master;
   assign s_run  = cfg.enable && !cfg.master;
   assign done   = cfg.master ? m_done : s_done;
   assign rx_mux = cfg.master ? m_rx : s_rx;

   spi_dm_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .irq_en(irq_en), .irq(irq),
      .done_i(done), .rx_i(rx_mux),
      .cfg_o(cfg), .data_wr(data_wr), .data_rd(data_rd),
      .avail_o(rx_avail), .ovr_o(rx_ovr)
   );

   spi_dm_master #(
      .DATA_W(DATA_W), .DIV_LOG_MAX(DIV_LOG_MAX), .HAS_EXT_SRC(HAS_EXT_SRC)
   ) u_master (
      .clk(clk), .rst_n(rst_n),
      .run(m_run), .ext_src(cfg.ext_src), .div(cfg.div), .cpol(cfg.cpol),
      .tick(tick_in), .load(data_wr && cfg.master), .load_data(reg_wdata),
      .sdi(sdi_i), .sclk(sclk_o), .sdo(m_sdo),
      .done(m_done), .rx_byte(m_rx), .busy(m_busy)
   );

   spi_dm_slave #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_slave (
      .clk(clk), .rst_n(rst_n),
      .run(s_run), .cpol(cfg.cpol), .ss_pol(cfg.ss_pol),
      .sclk_in(sclk_i), .ss_in(ss_i), .sdi_in(sdi_i),
      .load(data_wr && !cfg.master), .load_data(reg_wdata),
      .sdo(s_sdo), .done(s_done), .rx_byte(s_rx),
      .ss_act(s_ss_act), .bit_cnt(s_bitcnt)
   );

   assign sclk_oe = m_run;
   assign sdo_o   = cfg.master ? m_sdo : s_sdo;
   assign sdo_oe  = cfg.enable && (cfg.master || cfg.div[1]);
endmodule

// File: rtl/spi_dm_chk.sv
`timescale 1ns/1ps
module spi_dm_chk #(
   parameter int BC_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            en,
   input logic            master,
   input logic            oe_bit,
   input logic            irq,
   input logic            avail,
   input logic            ovr,
   input logic            done,
   input logic            data_rd,
   input logic            ctrl_clr,
   input logic            sclk_oe,
   input logic            sdo_oe,
   input logic            ss_act,
   input logic [BC_W-1:0] bitcnt
);
   a_r6_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!sclk_oe && !sdo_oe));

   a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> avail);

   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !done) |=> !avail);

   a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ctrl_clr) |=> ovr);

   a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr && !(done && avail)) |=> !ovr);

   a_r11_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_act |=> (bitcnt == '0));

   a_r12_slave_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !master && !oe_bit) |-> !sdo_oe);
endmodule

bind spi_duplex_port spi_dm_chk #(.BC_W($clog2(DATA_W))) u_chk (
   .clk(clk), .rst_n(rst_n),
   .en(cfg.enable), .master(cfg.master), .oe_bit(cfg.div[1]),
   .irq(irq), .avail(rx_avail), .ovr(rx_ovr),
   .done(done), .data_rd(data_rd),
   .ctrl_clr(reg_wr && !reg_addr && !reg_wdata[7] && !reg_wdata[1]),
   .sclk_oe(sclk_oe), .sdo_oe(sdo_oe),
   .ss_act(s_ss_act), .bitcnt(s_bitcnt)
);

// File: tb/tb_spi_duplex_port.sv
`timescale 1ns/1ps
module tb_spi_duplex_port;
   localparam int H = 8;   // slave half period in clocks

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_addr = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic irq_en = 1'b1, irq, tick_in = 1'b0;
   logic sclk_o, sclk_oe, sdo_o, sdo_oe;
   logic s_sclk = 1'b0, s_ss = 1'b1, s_sdi = 1'b0, m_sdi = 1'b0;
   logic use_m = 1'b1;
   logic sdi_i;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   assign sdi_i = use_m ? m_sdi : s_sdi;

   spi_duplex_port dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_en(irq_en), .irq(irq), .tick_in(tick_in),
      .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(s_sclk), .ss_i(s_ss),
      .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
   );

   // bench-side peer for master transfers
   logic       mon_on = 1'b0, mon_cpol = 1'b0;
   logic [7:0] mpat = '0, mcap = '0;
   int         midx = 7;
   always @(sclk_o) begin
      if (mon_on) begin
         if (sclk_o != mon_cpol) mcap = {mcap[6:0], sdo_o};
         else if (midx > 0) begin midx = midx - 1; m_sdi = mpat[midx]; end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b1;
   endtask

   task automatic rd_data(output logic [15:0] v);
      @(negedge clk); reg_addr = 1'b1; reg_rd = 1'b1; #1 v = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic peek(input logic a, output logic [15:0] v);
      reg_addr = a; #1 v = reg_rdata; reg_addr = 1'b1;
   endtask

   task automatic m_start(input logic cp, input logic [7:0] tx, input logic [7:0] pat);
      mon_cpol = cp; mpat = pat; mcap = '0; midx = 7; m_sdi = pat[7]; mon_on = 1'b1;
      wr_reg(1'b1, tx);
   endtask

   logic cpol_v = 1'b0, sspol_v = 1'b0;

   task automatic s_xfer(input logic [7:0] mosi, input int nbits, output logic [7:0] miso);
      miso = '0;
      s_ss = sspol_v;
      repeat (8) @(negedge clk);
      for (int i = 7; i > 7 - nbits; i--) begin
         s_sdi = mosi[i];
         repeat (H) @(negedge clk);
         miso = {miso[6:0], sdo_o};
         s_sclk = ~cpol_v;
         repeat (H) @(negedge clk);
         s_sclk = cpol_v;
      end
      repeat (8) @(negedge clk);
      s_ss = ~sspol_v;
      repeat (10) @(negedge clk);
   endtask

   logic [15:0] v;
   logic [7:0]  tx, pat, cap, ctrl;
   int          cnt;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      peek(1'b0, v); chk(v == 16'h0, "R1 ctrl", v, 0);
      peek(1'b1, v); chk(v == 16'h0, "R1 data", v, 0);
      chk({irq, sclk_oe, sdo_oe} == 3'b000, "R1 outputs", {irq, sclk_oe, sdo_oe}, 0);

      // R6 disabled master: data write does nothing
      wr_reg(1'b0, 8'h80);
      wr_reg(1'b1, 8'h5A);
      repeat (100) @(negedge clk);
      peek(1'b1, v); chk(v[14] == 1'b0, "R6 no transfer", v, 0);
      chk({sclk_oe, sdo_oe} == 2'b00, "R6 oe low", {sclk_oe, sdo_oe}, 0);

      // R2/R3 sweep master divider codes and clock polarity
      for (int cp = 0; cp < 2; cp++) begin
         for (int d = 0; d < 4; d++) begin
            tx  = 8'h3C ^ 8'(d * 37 + cp * 91);
            pat = {tx[3:0], ~tx[7:4]} ^ 8'h81;
            wr_reg(1'b0, 8'hA0 | 8'(cp << 3) | 8'(d << 1));
            m_start(cp[0], tx, pat);
            cnt = 0;
            while (!reg_rdata[14] && cnt < 1000) begin @(negedge clk); cnt++; end
            chk(cnt == (16 << d) + 1, "R2 length", cnt, (16 << d) + 1);
            chk(mcap == tx, "R3 tx bits", mcap, tx);
            chk(sclk_o == cp[0], "R3 idle level", sclk_o, cp);
            chk(irq == 1'b1, "R8 irq set", irq, 1);
            rd_data(v); mon_on = 1'b0;
            chk(v[7:0] == pat && v[15:14] == 2'b01, "R7 R3 rx word", v, {2'b01, 6'b0, pat});
            peek(1'b1, v); chk(v[14] == 1'b0, "R7 read clears", v[14], 0);
         end
      end

      // R5 write while busy is ignored
      wr_reg(1'b0, 8'hA6);
      m_start(1'b0, 8'hC3, 8'h18);
      repeat (40) @(negedge clk);
      wr_reg(1'b1, 8'h11);
      cnt = 0;
      while (!reg_rdata[14] && cnt < 1000) begin @(negedge clk); cnt++; end
      chk(mcap == 8'hC3, "R5 busy write", mcap, 8'hC3);
      rd_data(v); mon_on = 1'b0;

      // R4 external tick source
      wr_reg(1'b0, 8'hE0);
      m_start(1'b0, 8'h96, 8'h6B);
      repeat (50) @(negedge clk);
      peek(1'b1, v);
      chk(v[14] == 1'b0 && sclk_o == 1'b0, "R4 stalls without tick", v[14], 0);
      for (int t = 0; t < 16; t++) begin
         @(negedge clk); tick_in = 1'b1;
         @(negedge clk); tick_in = 1'b0;
         repeat (3) @(negedge clk);
      end
      peek(1'b1, v);
      chk(v[14] == 1'b1 && v[7:0] == 8'h6B, "R4 rx", v, 16'h406B);
      chk(mcap == 8'h96, "R4 tx", mcap, 8'h96);
      rd_data(v); mon_on = 1'b0;

      // R13 control readback in master mode
      wr_reg(1'b0, 8'hEF);
      peek(1'b0, v); chk(v == 16'h00EF & ~16'h0010, "R13 readback", v, 16'h00EF & ~16'h0010);

      // R10 slave sweep over clock and select polarity
      use_m = 1'b0;
      for (int cp = 0; cp < 2; cp++) begin
         for (int sp = 0; sp < 2; sp++) begin
            cpol_v = cp[0]; sspol_v = sp[0];
            s_sclk = cpol_v; s_ss = ~sspol_v;
            repeat (4) @(negedge clk);
            wr_reg(1'b0, 8'h24 | 8'(cp << 3) | 8'(sp));
            repeat (10) @(negedge clk);
            tx = 8'hA1 + 8'(cp * 16 + sp * 5);
            wr_reg(1'b1, tx);
            s_xfer(~tx ^ 8'h0F, 8, cap);
            chk(cap == tx, "R10 slave tx", cap, tx);
            rd_data(v);
            chk(v[15:14] == 2'b01 && v[7:0] == (~tx ^ 8'h0F), "R10 slave rx", v, {8'h40, ~tx ^ 8'h0F});
         end
      end

      // R12 slave data-out enable
      chk(sdo_oe == 1'b1, "R12 oe on", sdo_oe, 1);
      ctrl = 8'h2B;   // slave, enable, cpol 1, sspol 1, oe 0, bit1 1 (no clear)
      wr_reg(1'b0, ctrl);
      chk(sdo_oe == 1'b0, "R12 oe off", sdo_oe, 0);

      // R11 partial byte discarded
      repeat (10) @(negedge clk);
      s_xfer(8'hF0, 3, cap);
      peek(1'b1, v); chk(v[14] == 1'b0, "R11 no flag", v[14], 0);
      wr_reg(1'b1, 8'h5D);
      s_xfer(8'h27, 8, cap);
      chk(cap == 8'h5D, "R11 tx after restart", cap, 8'h5D);
      peek(1'b1, v); chk(v[7:0] == 8'h27 && v[14], "R11 rx after restart", v, 16'h4027);

      // R9 overrun in slave mode, R8 irq gated by enable
      irq_en = 1'b0;
      s_xfer(8'h99, 8, cap);
      chk(irq == 1'b0, "R8 irq masked", irq, 0);
      peek(1'b0, v); chk(v[1] == 1'b1 && v[4] == 1'b1, "R9 ctrl bit1 overrun", v, 16'h0012);
      rd_data(v);
      chk(v[15:14] == 2'b11 && v[7:0] == 8'h99, "R9 data overrun", v, 16'hC099);
      wr_reg(1'b0, 8'h29);   // bits 7 and 1 zero: clears
      peek(1'b0, v); chk(v[1] == 1'b0, "R9 cleared ctrl", v[1], 0);
      peek(1'b1, v); chk(v[15] == 1'b0, "R9 cleared data", v[15], 0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule